// File: doc/BRIEF.md
# Codeword Aligner and Parity Stripper for a 10G PON Receive Path

This block sits after block lock in a 10G PON receiver. It takes a stream of 66-bit words, each a 2-bit sync header and a 64-bit payload, and finds where each forward-error-correction codeword starts. A codeword is 31 words long: 27 message words, then 4 parity words. Message words always carry header 01 or 10. The four parity words carry the headers 00, 11, 11, 00 in that order, and no other run of words can produce that sequence.

The block searches for the parity header sequence and confirms it at the 31-word spacing before it declares lock. Once locked, it removes the parity words and descrambles the message payloads with a self-synchronous descrambler. It delivers each message word with its header, its index inside the codeword and a header-error flag. The parity words are dropped, not used for correction.

Both stream edges use valid/ready. An input word is taken when `in_valid` and `in_ready` are both high. An output beat leaves when `o_valid` and `o_ready` are both high. While an output beat is stalled, `in_ready` is low and no further input word is accepted, so no word is lost.

Top module: `fca_aligner`

## Requirements
- R1: Each codeword is 31 accepted words. Only the message words, at positions 0 to 26, reach the output, with `o_idx` giving the position. The parity words at positions 27 to 30 are never output.
- R2: Lock (`o_locked` = 1) is declared when the header sequence 00,11,11,00 ends three codewords in a row at 31-word spacing. The first output beat is word 0 of the next codeword.
- R3: While `o_locked` is 0, `o_valid` stays 0. If the confirming codeword after a first match does not end in the parity header sequence, the search restarts.
- R4: The output payload is the input payload descrambled with the polynomial 1 + x^39 + x^58. Bit 0 is the earliest bit in time. Each output bit is the input bit XOR the received bits 39 and 58 positions earlier. The header passes through unchanged. The descrambler history advances only on message words.
- R5: A message word that arrives while locked with header 00 or 11 is still output, with `o_herr` = 1. Its codeword counts as bad.
- R6: While locked, a codeword is bad if any message header is invalid or its parity header sequence is wrong. After 4 bad codewords in a row, lock is dropped. A good codeword resets that count.
- R7: After losing lock, the block searches again at every word position and locks again after three further matching codewords.
- R8: While `o_valid` = 1 and `o_ready` = 0, `o_valid`, `o_hdr`, `o_data`, `o_idx` and `o_herr` hold their values, and `in_ready` is 0.
- R9: During reset, `o_valid` = 0, `o_locked` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted this cycle if valid |
| in_hdr | input | 2 | Sync header of the input word |
| in_data | input | 64 | Scrambled payload of the input word |
| o_valid | output | 1 | Output beat present |
| o_ready | input | 1 | Downstream accepts the beat |
| o_hdr | output | 2 | Sync header of the output word |
| o_data | output | 64 | Descrambled payload |
| o_idx | output | 5 | Position of the word in its codeword (0 to 26) |
| o_herr | output | 1 | Output word had an invalid header (00 or 11) |
| o_locked | output | 1 | Codeword lock flag |

## Verification
Two functions can meet in one cycle: a header-error flag on an output beat, and a downstream stall of that same beat. To provoke this, the bench pulls `o_ready` low for several cycles whenever a flagged beat is presented. It plants a bad header both mid-codeword and on the last message word, index 26, which is directly followed by the parity run that closes the bad codeword. The stalled beat must keep its flag, payload and index unchanged, and input must stay blocked. The counts of bad codewords, and the resulting lock or loss seen on `o_locked` after each codeword, must match what the requirements predict.

// File: rtl/fca_pkg.sv
package fca_pkg;

  typedef enum logic [1:0] {
    FR_HUNT  = 2'd0,
    FR_CHECK = 2'd1,
    FR_LOCK  = 2'd2
  } frame_st_t;

  // a message header is 01 or 10
  function automatic logic hdr_ok(input logic [1:0] h);
    return h[1] ^ h[0];
  endfunction

endpackage

// File: rtl/fca_pardet.sv
module fca_pardet #(
  parameter int PAR_WORDS = 4,
  parameter logic [2*PAR_WORDS-1:0] PATTERN = 8'b00_11_11_00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [1:0] hdr,
  output logic       match
);
  localparam int HIST_W = 2 * (PAR_WORDS - 1);
  localparam int WIN_W  = 2 * PAR_WORDS;

  logic [HIST_W-1:0]    hist;
  logic [WIN_W-1:0]     window;
  logic [PAR_WORDS-1:0] slot_eq;

  // oldest header in the most significant slot
  assign window = {hist, hdr};

  for (genvar s = 0; s < PAR_WORDS; s++) begin : g_slot
    assign slot_eq[s] = (window[2*s +: 2] == PATTERN[2*s +: 2]);
  end

  assign match = &slot_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hist <= '0;
    else if (step) hist <= window[HIST_W-1:0];
  end
endmodule

// File: rtl/fca_framer.sv
module fca_framer
  import fca_pkg::*;
#(
  parameter int CW_WORDS   = 31,
  parameter int MSG_WORDS  = 27,
  parameter int LOCK_HITS  = 3,
  parameter int LOSS_LIMIT = 4,
  parameter int IDX_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [1:0]       hdr,
  input  logic             par_match,
  output logic [IDX_W-1:0] pos,
  output logic             is_msg,
  output logic             emit,
  output logic             locked
);
  localparam int HIT_W  = $clog2(LOCK_HITS + 1);
  localparam int LOSS_W = $clog2(LOSS_LIMIT + 1);
  localparam logic [HIT_W-1:0]  HIT_LAST  = HIT_W'(LOCK_HITS - 1);
  localparam logic [LOSS_W-1:0] LOSS_LAST = LOSS_W'(LOSS_LIMIT - 1);
  localparam logic [IDX_W-1:0]  POS_LAST  = IDX_W'(CW_WORDS - 1);
  localparam logic [IDX_W-1:0]  MSG_END   = IDX_W'(MSG_WORDS);

  frame_st_t          st;
  logic [HIT_W-1:0]   hits;
  logic [LOSS_W-1:0]  loss;
  logic               cw_bad;
  logic               in_msg;
  logic               at_end;

  assign in_msg = (pos < MSG_END);
  assign at_end = (pos == POS_LAST);
  assign is_msg = (st == FR_HUNT) ? hdr_ok(hdr) : in_msg;
  assign emit   = (st == FR_LOCK) && in_msg;
  assign locked = (st == FR_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= FR_HUNT;
      pos    <= '0;
      hits   <= '0;
      loss   <= '0;
      cw_bad <= 1'b0;
    end else if (step) begin
      unique case (st)
        FR_HUNT: begin
          if (par_match) begin
            st   <= FR_CHECK;
            hits <= HIT_W'(1);
            pos  <= '0;
          end
        end
        FR_CHECK: begin
          if (at_end) begin
            pos <= '0;
            if (!par_match) begin
              st <= FR_HUNT;
            end else if (hits == HIT_LAST) begin
              st     <= FR_LOCK;
              loss   <= '0;
              cw_bad <= 1'b0;
            end else begin
              hits <= hits + 1'b1;
            end
          end else begin
            pos <= pos + 1'b1;
          end
        end
        FR_LOCK: begin
          if (at_end) begin
            pos    <= '0;
            cw_bad <= 1'b0;
            if (cw_bad || !par_match) begin
              if (loss == LOSS_LAST) begin
                st   <= FR_HUNT;
                loss <= '0;
              end else begin
                loss <= loss + 1'b1;
              end
            end else begin
              loss <= '0;
            end
          end else begin
            pos <= pos + 1'b1;
            if (in_msg && !hdr_ok(hdr)) cw_bad <= 1'b1;
          end
        end
        default: st <= FR_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/fca_descrambler.sv
module fca_descrambler #(
  parameter int DATA_W = 64,
  parameter int TAP_A  = 39,
  parameter int TAP_B  = 58
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int EXT_W = DATA_W + TAP_B;

  // hist[TAP_B-1] is the most recent received bit
  logic [TAP_B-1:0] hist;
  logic [EXT_W-1:0] ext;

  assign ext = {din, hist};

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign dout[i] = din[i] ^ ext[i + TAP_B - TAP_A] ^ ext[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist <= '0;
    else if (advance) hist <= ext[EXT_W-1:DATA_W];
  end
endmodule

// File: rtl/fca_aligner.sv
module fca_aligner
  import fca_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int CW_WORDS   = 31,
  parameter int PAR_WORDS  = 4,
  parameter logic [2*PAR_WORDS-1:0] PAR_PATTERN = 8'b00_11_11_00,
  parameter int LOCK_HITS  = 3,
  parameter int LOSS_LIMIT = 4,
  parameter int TAP_A      = 39,
  parameter int TAP_B      = 58,
  localparam int MSG_WORDS = CW_WORDS - PAR_WORDS,
  localparam int IDX_W     = $clog2(CW_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_hdr,
  input  logic [DATA_W-1:0] in_data,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [1:0]        o_hdr,
  output logic [DATA_W-1:0] o_data,
  output logic [IDX_W-1:0]  o_idx,
  output logic              o_herr,
  output logic              o_locked
);
  logic              beat;
  logic              par_match;
  logic [IDX_W-1:0]  pos;
  logic              is_msg;
  logic              emit;
  logic [DATA_W-1:0] plain;

  assign in_ready = !o_valid || o_ready;
  assign beat     = in_valid && in_ready;

  fca_pardet #(
    .PAR_WORDS (PAR_WORDS),
    .PATTERN   (PAR_PATTERN)
  ) u_pardet (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (beat),
    .hdr   (in_hdr),
    .match (par_match)
  );

  fca_framer #(
    .CW_WORDS   (CW_WORDS),
    .MSG_WORDS  (MSG_WORDS),
    .LOCK_HITS  (LOCK_HITS),
    .LOSS_LIMIT (LOSS_LIMIT),
    .IDX_W      (IDX_W)
  ) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (beat),
    .hdr       (in_hdr),
    .par_match (par_match),
    .pos       (pos),
    .is_msg    (is_msg),
    .emit      (emit),
    .locked    (o_locked)
  );

  fca_descrambler #(
    .DATA_W (DATA_W),
    .TAP_A  (TAP_A),
    .TAP_B  (TAP_B)
  ) u_descr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (beat && is_msg),
    .din     (in_data),
    .dout    (plain)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_hdr   <= '0;
      o_data  <= '0;
      o_idx   <= '0;
      o_herr  <= 1'b0;
    end else if (beat && emit) begin
      o_valid <= 1'b1;
      o_hdr   <= in_hdr;
      o_data  <= plain;
      o_idx   <= pos;
      o_herr  <= !hdr_ok(in_hdr);
    end else if (o_ready) begin
      o_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fca_aligner_chk.sv
module fca_aligner_chk #(
  parameter int DATA_W    = 64,
  parameter int IDX_W     = 5,
  parameter int MSG_WORDS = 27
) (
  input logic              clk,
  input logic              rst_n,
  input logic              o_valid,
  input logic              o_ready,
  input logic              in_ready,
  input logic [1:0]        o_hdr,
  input logic [DATA_W-1:0] o_data,
  input logic [IDX_W-1:0]  o_idx,
  input logic              o_herr,
  input logic              o_locked
);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_hdr)
                               && $stable(o_idx) && $stable(o_herr)));

  assert_stall_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |-> !in_ready);

  assert_quiet_unlocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> o_locked);

  assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (o_idx < IDX_W'(MSG_WORDS)));

  assert_clean_hdr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_herr) |-> (o_hdr[1] ^ o_hdr[0]));

  assert_lock_on_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_locked) |-> !o_valid);
endmodule

bind fca_aligner fca_aligner_chk u_chk (.*);

// File: tb/fca_aligner_test.sv
module fca_aligner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_hdr = 2'b01;
  logic [63:0] in_data = '0;
  logic        o_valid;
  logic        o_ready = 1'b0;
  logic [1:0]  o_hdr;
  logic [63:0] o_data;
  logic [4:0]  o_idx;
  logic        o_herr;
  logic        o_locked;

  always #2.5 clk = ~clk;

  fca_aligner uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_data(in_data), .o_valid(o_valid), .o_ready(o_ready),
    .o_hdr(o_hdr), .o_data(o_data), .o_idx(o_idx), .o_herr(o_herr),
    .o_locked(o_locked)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // entry: [9:5] bad index (31 none), [4:3] bad header, [2] broken parity,
  //        [1] data expected on output, [0] lock expected afterwards
  localparam int NCW = 17;
  localparam logic [9:0] TBL [NCW] = '{
    {5'd31, 2'b00, 1'b0, 1'b0, 1'b0},  // 0 first match
    {5'd31, 2'b00, 1'b0, 1'b0, 1'b0},  // 1 second match
    {5'd31, 2'b00, 1'b0, 1'b0, 1'b1},  // 2 third match -> lock
    {5'd31, 2'b00, 1'b0, 1'b1, 1'b1},  // 3 first output codeword
    {5'd5,  2'b00, 1'b0, 1'b1, 1'b1},  // 4 header error, bad 1
    {5'd31, 2'b00, 1'b1, 1'b1, 1'b1},  // 5 parity broken, bad 2
    {5'd31, 2'b00, 1'b0, 1'b1, 1'b1},  // 6 good clears count
    {5'd31, 2'b00, 1'b1, 1'b1, 1'b1},  // 7 bad 1
    {5'd31, 2'b00, 1'b1, 1'b1, 1'b1},  // 8 bad 2
    {5'd26, 2'b11, 1'b0, 1'b1, 1'b1},  // 9 bad 3 on last message word
    {5'd31, 2'b00, 1'b1, 1'b1, 1'b0},  // 10 bad 4 -> loss
    {5'd31, 2'b00, 1'b0, 1'b0, 1'b0},  // 11 match 1
    {5'd31, 2'b00, 1'b1, 1'b0, 1'b0},  // 12 confirm fails
    {5'd31, 2'b00, 1'b0, 1'b0, 1'b0},  // 13 match 1
    {5'd31, 2'b00, 1'b0, 1'b0, 1'b0},  // 14 match 2
    {5'd31, 2'b00, 1'b0, 1'b0, 1'b1},  // 15 match 3 -> relock
    {5'd31, 2'b00, 1'b0, 1'b1, 1'b1}   // 16 output again
  };

  localparam int QN = 1024;
  logic [1:0]  wr_hdr [QN];
  logic [63:0] wr_dat [QN];
  int wp = 0, rp = 0;

  logic [1:0]  ex_hdr [QN];
  logic [63:0] ex_dat [QN];
  logic [4:0]  ex_idx [QN];
  logic        ex_err [QN];
  int ex_n = 0;

  logic [1:0]  cp_hdr [QN];
  logic [63:0] cp_dat [QN];
  logic [4:0]  cp_idx [QN];
  logic        cp_err [QN];
  int cp_n = 0;

  logic [57:0] sh = '0;          // bench scrambler history, newest in bit 0
  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;
  int          cyc = 0;
  int          hold = 0;
  bit          prev_stall = 0;
  logic [63:0] prev_dat = '0;
  logic [4:0]  prev_idx = '0;
  logic        prev_err = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic next_rand(output logic [63:0] r);
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    r  = rs;
  endtask

  // bit-serial reference: s = p ^ s(-39) ^ s(-58), bit 0 first
  task automatic scramble(input logic [63:0] p, output logic [63:0] s);
    for (int i = 0; i < 64; i++) begin
      logic b;
      b    = p[i] ^ sh[38] ^ sh[57];
      s[i] = b;
      sh   = {sh[56:0], b};
    end
  endtask

  task automatic push(input logic [1:0] h, input logic [63:0] d);
    wr_hdr[wp] = h;
    wr_dat[wp] = d;
    wp++;
  endtask

  task automatic push_msg(input logic [1:0] h, input logic [63:0] p,
                          input int idx, input bit want);
    logic [63:0] s;
    scramble(p, s);
    push(h, s);
    if (want) begin
      ex_hdr[ex_n] = h;
      ex_dat[ex_n] = p;
      ex_idx[ex_n] = 5'(idx);
      ex_err[ex_n] = (h == 2'b00) || (h == 2'b11);
      ex_n++;
    end
  endtask

  task automatic build_cw(input logic [9:0] e);
    logic [63:0] p;
    logic [1:0]  h;
    for (int w = 0; w < 27; w++) begin
      next_rand(p);
      h = p[7] ? 2'b01 : 2'b10;
      if (w == int'(e[9:5])) h = e[4:3];
      push_msg(h, p, w, e[1]);
    end
    next_rand(p); push(2'b00, p);
    next_rand(p); push(2'b11, p);
    next_rand(p); push(2'b11, p);
    next_rand(p); push(e[2] ? 2'b11 : 2'b00, p);
  endtask

  task automatic step();
    logic rdy;
    @(negedge clk);
    cyc++;
    rdy = (cyc % 5 != 3);
    if (o_valid && o_herr && hold < 4) begin
      rdy = 1'b0;
      hold++;
    end
    o_ready = rdy;
    if (rp < wp) begin
      in_valid = 1'b1;
      in_hdr   = wr_hdr[rp];
      in_data  = wr_dat[rp];
    end else begin
      in_valid = 1'b0;
    end
    #1;
    if (prev_stall) begin
      // R8: stalled beat keeps its content
      check(o_valid && o_data == prev_dat && o_idx == prev_idx && o_herr == prev_err,
            "R8", "stalled beat changed", o_data, prev_dat);
    end
    if (o_valid && !o_ready)
      check(!in_ready, "R8", "input taken during stall", 64'(in_ready), 64'd0);
    prev_stall = o_valid && !o_ready;
    prev_dat   = o_data;
    prev_idx   = o_idx;
    prev_err   = o_herr;
    if (o_valid && o_ready) begin
      cp_hdr[cp_n] = o_hdr;
      cp_dat[cp_n] = o_data;
      cp_idx[cp_n] = o_idx;
      cp_err[cp_n] = o_herr;
      cp_n++;
      hold = 0;
    end
    if (in_valid && in_ready) rp++;
  endtask

  // pause one cycle with the output held, then look at the lock flag
  task automatic lock_check(input bit exp, input string req);
    @(negedge clk);
    o_ready  = 1'b0;
    in_valid = 1'b0;
    #1;
    check(o_locked == exp, req, "lock flag after codeword", 64'(o_locked), 64'(exp));
    prev_stall = o_valid;
    prev_dat   = o_data;
    prev_idx   = o_idx;
    prev_err   = o_herr;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R9: reset state
    check(!o_valid && !o_locked && in_ready, "R9", "reset state",
          {61'd0, o_valid, o_locked, in_ready}, 64'd1);
    rst_n = 1'b1;

    // stray message words before the first codeword boundary
    for (int j = 0; j < 3; j++) begin
      logic [63:0] p;
      next_rand(p);
      push_msg(2'b10, p, 0, 1'b0);
    end

    for (int k = 0; k < NCW; k++) begin
      string req;
      req = (k <= 3) ? "R2" : ((k <= 10) ? "R6" : ((k == 12) ? "R3" : "R7"));
      build_cw(TBL[k]);
      while (rp < wp) step();
      lock_check(TBL[k][0], req);
    end
    repeat (12) step();

    // R3: nothing emitted beyond the locked codewords
    check(cp_n == ex_n, "R3", "output beat count", 64'(cp_n), 64'(ex_n));
    for (int i = 0; i < ex_n && i < cp_n; i++) begin
      check(cp_idx[i] == ex_idx[i], "R1", "word index", 64'(cp_idx[i]), 64'(ex_idx[i]));
      check(cp_dat[i] == ex_dat[i] && cp_hdr[i] == ex_hdr[i], "R4", "descrambled payload",
            cp_dat[i], ex_dat[i]);
      check(cp_err[i] == ex_err[i], "R5", "header error flag",
            64'(cp_err[i]), 64'(ex_err[i]));
    end

    // R9: reset in the middle of a locked codeword
    build_cw({5'd31, 2'b00, 1'b0, 1'b1, 1'b1});
    repeat (15) step();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!o_valid && !o_locked && in_ready, "R9", "state under mid-stream reset",
          {61'd0, o_valid, o_locked, in_ready}, 64'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule